// File: doc/BRIEF.md
# Chip-Select Cycle Termination Generator

This block ends a bus cycle that a chip-select channel has claimed. It produces an internal, active-low, two-bit acknowledge, which also tells the bus master how wide the responding port is. While the cycle strobe is high, the block counts clocks. It asserts the acknowledge once the channel's programmed delay has elapsed. That delay is either a short fast-termination access or a normal access stretched by zero to six wait states.

The channel's attributes are sampled in the first clock of each cycle, together with the access type. The attributes are the claim flag, port width, wait count, fast-termination flag and write protection. The access type is read or write, byte or word, and the byte address bit. A boot-global input replaces the attributes with a safe default: a 16-bit port with six wait states and no write protection. In that mode every cycle is claimed, so a boot memory can answer before software has set up the channels. Address decoding and the register file sit outside this block.

Top module: `cs_term_gen`

## Requirements
- R1: While reset is asserted, and after reset with the strobe low, `ack_n` is 2'b11, which means no acknowledge.
- R2: For a normal cycle with wait count W, `ack_n` asserts in clock 3+W of the strobe. Clock 1 is the clock whose closing edge first samples the strobe high.
- R3: A wait count above 6 acts as 6.
- R4: With fast termination set, `ack_n` asserts in clock 2 of the strobe, whatever the wait count.
- R5: The acknowledge code is 2'b01 for an 8-bit port (`port16`=0) and 2'b10 for a 16-bit port (`port16`=1). The code 2'b00 never appears.
- R6: An 8-bit port acknowledges byte accesses at odd and even addresses, and word accesses.
- R7: A 16-bit port acknowledges odd bytes, even bytes and even words. A word at an odd address (`word_acc`=1, `addr_lsb`=1) gets no acknowledge.
- R8: A cycle that no chip select claims (`cs_hit`=0) gets no acknowledge.
- R9: A write (`wr`=1) to a write-protected channel gets no acknowledge. Reads of that channel are acknowledged normally.
- R10: With `boot_global`=1, every cycle is claimed as a 16-bit port with six wait states. Write protection, fast termination, port size and hit are all ignored.
- R11: `ack_n` returns to 2'b11 in the same clock that the strobe goes low. The next cycle counts from the start again.
- R12: Attributes are taken in the first clock of the strobe. Changes to them later in the same cycle have no effect.
- R13: Once asserted, the acknowledge holds its code for as long as the strobe stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_strobe | input | 1 | High for the duration of a bus cycle |
| cs_hit | input | 1 | A chip-select channel claims this cycle |
| boot_global | input | 1 | Use the boot default attributes |
| wr | input | 1 | 1 = write, 0 = read |
| wprot | input | 1 | Channel is write-protected |
| fast_term | input | 1 | Channel uses fast termination |
| wait_sel | input | WAIT_W | Programmed wait-state count |
| port16 | input | 1 | 1 = 16-bit port, 0 = 8-bit port |
| word_acc | input | 1 | 1 = word access, 0 = byte access |
| addr_lsb | input | 1 | Byte address bit 0 |
| ack_n | output | 2 | Active-low acknowledge code |

## Verification
The acknowledge comes from a registered clock counter that is gated combinationally by the live strobe. Assertion is therefore due one clock after the counter edge that reaches the target: clock 2 for fast termination and clock 3+W for a normal cycle. Release is due in the very clock the strobe drops. The bench drives inputs on falling edges and compares `ack_n` shortly after each falling edge against a behavioural model. That model counts strobe-high rising edges and latches attributes on the first one, so every clock of every cycle is checked, including the exact clock of assertion and release.

// File: rtl/cs_term_pkg.sv
package cs_term_pkg;
   typedef enum logic [1:0] {
      ACK_NONE = 2'b11,
      ACK_P8   = 2'b01,
      ACK_P16  = 2'b10
   } ack_code_e;

   function automatic ack_code_e width_code(input logic is16);
      return is16 ? ACK_P16 : ACK_P8;
   endfunction
endpackage

// File: rtl/cs_attr_sel.sv
module cs_attr_sel #(
   parameter int MAX_WAIT     = 6,
   parameter int BOOT_WAITS   = 6,
   parameter int WAIT_W       = 3,
   parameter int CNT_W        = 5,
   parameter bit FAST_SUPPORT = 1'b1
) (
   input  logic              boot_global,
   input  logic              cs_hit,
   input  logic              wr,
   input  logic              wprot,
   input  logic              fast_term,
   input  logic [WAIT_W-1:0] wait_sel,
   input  logic              port16,
   input  logic              word_acc,
   input  logic              addr_lsb,
   output logic              claim,
   output logic              p16_eff,
   output logic [CNT_W-1:0]  target
);
   localparam logic [CNT_W-1:0] MAXW_C = CNT_W'(MAX_WAIT);
   localparam logic [CNT_W-1:0] BOOT_C = CNT_W'(BOOT_WAITS);
   localparam logic [CNT_W-1:0] BASE_C = CNT_W'(2);
   localparam logic [CNT_W-1:0] FAST_C = CNT_W'(1);

   logic             wp_block;
   logic             odd_word;
   logic             use_fast;
   logic [CNT_W-1:0] wide_wait;
   logic [CNT_W-1:0] clamped;

   initial begin
      assert_width_R3: assert (CNT_W > WAIT_W && MAX_WAIT >= 0 && BOOT_WAITS <= MAX_WAIT)
         else $error("cs_attr_sel: bad parameter set");
   end

   always_comb begin
      p16_eff   = boot_global | port16;
      wp_block  = ~boot_global & wr & wprot;
      odd_word  = p16_eff & word_acc & addr_lsb;
      claim     = (boot_global | cs_hit) & ~wp_block & ~odd_word;
      wide_wait = {{(CNT_W-WAIT_W){1'b0}}, wait_sel};
      clamped   = (wide_wait > MAXW_C) ? MAXW_C : wide_wait;
   end

   generate
      if (FAST_SUPPORT) begin : g_fast
         assign use_fast = fast_term & ~boot_global;
      end else begin : g_nofast
         assign use_fast = 1'b0;
      end
   endgenerate

   always_comb begin
      if (use_fast)         target = FAST_C;
      else if (boot_global) target = BASE_C + BOOT_C;
      else                  target = BASE_C + clamped;
   end
endmodule

// File: rtl/cs_wait_ctr.sv
module cs_wait_ctr #(
   parameter int MAX_WAIT = 6,
   parameter int CNT_W    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_strobe,
   input  logic             claim_in,
   input  logic             p16_in,
   input  logic [CNT_W-1:0] target_in,
   output logic             lat_claim,
   output logic             lat_p16,
   output logic             done
);
   localparam logic [CNT_W-1:0] TOP_C = CNT_W'(MAX_WAIT + 2);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lat_target;
   logic             first;

   assign first = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         lat_target <= '0;
         lat_claim  <= 1'b0;
         lat_p16    <= 1'b0;
      end else if (!cyc_strobe) begin
         cnt <= '0;
      end else begin
         if (first) begin
            lat_claim  <= claim_in;
            lat_p16    <= p16_in;
            lat_target <= target_in;
            cnt        <= {{(CNT_W-1){1'b0}}, 1'b1};
         end else if (cnt < lat_target) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign done = (cnt != '0) && (cnt >= lat_target);

   assert_idle_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_strobe |=> cnt == '0);
   assert_attr_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_strobe && $past(cyc_strobe) && $past(cnt) != '0) |-> ($stable(lat_p16) && $stable(lat_target)));
   assert_target_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lat_target <= TOP_C);
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TOP_C);
endmodule

// File: rtl/cs_ack_enc.sv
module cs_ack_enc
   import cs_term_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cyc_strobe,
   input  logic       done,
   input  logic       lat_claim,
   input  logic       lat_p16,
   output logic [1:0] ack_n
);
   ack_code_e code;

   always_comb begin
      if (cyc_strobe && done && lat_claim) code = width_code(lat_p16);
      else                                 code = ACK_NONE;
   end

   assign ack_n = code;

   assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_strobe |-> ack_n == 2'b11);
   assert_legal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_n != 2'b00);
   assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_strobe && $past(cyc_strobe) && $past(ack_n) != 2'b11) |-> $stable(ack_n));
endmodule

// File: rtl/cs_term_gen.sv
module cs_term_gen #(
   parameter int MAX_WAIT     = 6,
   parameter int BOOT_WAITS   = 6,
   parameter int WAIT_W       = 3,
   parameter bit FAST_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_strobe,
   input  logic              cs_hit,
   input  logic              boot_global,
   input  logic              wr,
   input  logic              wprot,
   input  logic              fast_term,
   input  logic [WAIT_W-1:0] wait_sel,
   input  logic              port16,
   input  logic              word_acc,
   input  logic              addr_lsb,
   output logic [1:0]        ack_n
);
   localparam int CNT_W = $clog2(MAX_WAIT + 3) + 1;

   logic             claim;
   logic             p16_eff;
   logic [CNT_W-1:0] target;
   logic             lat_claim;
   logic             lat_p16;
   logic             done;

   cs_attr_sel #(
      .MAX_WAIT(MAX_WAIT), .BOOT_WAITS(BOOT_WAITS), .WAIT_W(WAIT_W),
      .CNT_W(CNT_W), .FAST_SUPPORT(FAST_SUPPORT)
   ) u_sel (
      .boot_global(boot_global), .cs_hit(cs_hit), .wr(wr), .wprot(wprot),
      .fast_term(fast_term), .wait_sel(wait_sel), .port16(port16),
      .word_acc(word_acc), .addr_lsb(addr_lsb),
      .claim(claim), .p16_eff(p16_eff), .target(target)
   );

   cs_wait_ctr #(.MAX_WAIT(MAX_WAIT), .CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe),
      .claim_in(claim), .p16_in(p16_eff), .target_in(target),
      .lat_claim(lat_claim), .lat_p16(lat_p16), .done(done)
   );

   cs_ack_enc u_enc (
      .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .done(done),
      .lat_claim(lat_claim), .lat_p16(lat_p16), .ack_n(ack_n)
   );

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ack_n == 2'b11);
endmodule

// File: tb/test_cs_term_gen.sv
`timescale 1ns/100ps
module test_cs_term_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_strobe = 1'b0;
   logic       cs_hit = 1'b0;
   logic       boot_global = 1'b0;
   logic       wr = 1'b0;
   logic       wprot = 1'b0;
   logic       fast_term = 1'b0;
   logic [2:0] wait_sel = 3'd0;
   logic       port16 = 1'b0;
   logic       word_acc = 1'b0;
   logic       addr_lsb = 1'b0;
   logic [1:0] ack_n;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";

   // behavioural reference state
   int m_n = 0;
   bit m_ok = 0;
   bit m_p16 = 0;
   int m_tgt = 0;

   always #2.5 clk = ~clk;

   cs_term_gen i_cs_term_gen (
      .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .cs_hit(cs_hit),
      .boot_global(boot_global), .wr(wr), .wprot(wprot), .fast_term(fast_term),
      .wait_sel(wait_sel), .port16(port16), .word_acc(word_acc),
      .addr_lsb(addr_lsb), .ack_n(ack_n)
   );

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: ack_n actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // reference model: counts rising edges with strobe high, latches attributes on the first
   always @(posedge clk) begin
      if (!rst_n || !cyc_strobe) begin
         m_n = 0;
      end else begin
         if (m_n == 0) begin
            bit p16e;
            int w;
            p16e  = boot_global || port16;
            m_p16 = p16e;
            m_ok  = (boot_global || cs_hit) && !(!boot_global && wr && wprot)
                    && !(p16e && word_acc && addr_lsb);
            w     = (wait_sel > 6) ? 6 : int'(wait_sel);
            if (boot_global)    m_tgt = 2 + 6;
            else if (fast_term) m_tgt = 1;
            else                m_tgt = 2 + w;
         end
         if (m_n < 1000) m_n++;
      end
   end

   always @(negedge clk) begin
      logic [1:0] exp;
      #1;
      if (!cyc_strobe)                  exp = 2'b11;
      else if (m_ok && m_n >= m_tgt)    exp = m_p16 ? 2'b10 : 2'b01;
      else                              exp = 2'b11;
      check(cur_req, ack_n, exp);
   end

   task automatic run(input string req, input bit hit, input bit boot, input bit w_r,
                      input bit wp, input bit fast, input int ws, input bit p16,
                      input bit word, input bit a0, input int hold, input bit mutate);
      @(negedge clk);
      cur_req     = req;
      cs_hit      = hit;
      boot_global = boot;
      wr          = w_r;
      wprot       = wp;
      fast_term   = fast;
      wait_sel    = 3'(ws);
      port16      = p16;
      word_acc    = word;
      addr_lsb    = a0;
      cyc_strobe  = 1'b1;
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         if (mutate && i == 0) begin
            port16    = ~port16;
            wait_sel  = 3'd0;
            cs_hit    = 1'b0;
            fast_term = 1'b1;
            wr        = 1'b1;
            wprot     = 1'b1;
         end
      end
      @(negedge clk);
      cyc_strobe = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: idle code during and after reset
      cur_req = "R1";
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1 check("R1", ack_n, 2'b11);

      //   req    hit boot wr wp fast ws p16 wd a0 hold mut
      run("R2", 1, 0, 0, 0, 0, 0, 1, 0, 0, 6,  0);
      run("R2", 1, 0, 0, 0, 0, 3, 1, 0, 1, 9,  0);
      run("R2", 1, 0, 0, 0, 0, 6, 0, 0, 0, 12, 0);
      run("R3", 1, 0, 0, 0, 0, 7, 1, 0, 0, 12, 0);
      run("R4", 1, 0, 0, 0, 1, 5, 1, 0, 0, 5,  0);
      run("R4", 1, 0, 1, 0, 1, 0, 0, 0, 1, 4,  0);
      run("R5", 1, 0, 0, 0, 0, 1, 0, 0, 0, 6,  0);
      run("R5", 1, 0, 0, 0, 0, 1, 1, 0, 0, 6,  0);
      run("R6", 1, 0, 0, 0, 0, 2, 0, 0, 1, 7,  0);
      run("R6", 1, 0, 0, 0, 0, 2, 0, 1, 1, 7,  0);
      run("R7", 1, 0, 0, 0, 0, 2, 1, 0, 1, 7,  0);
      run("R7", 1, 0, 0, 0, 0, 2, 1, 1, 0, 7,  0);
      run("R7", 1, 0, 0, 0, 0, 2, 1, 1, 1, 7,  0);
      run("R8", 0, 0, 0, 0, 1, 0, 1, 0, 0, 6,  0);
      run("R9", 1, 0, 1, 1, 0, 1, 1, 0, 0, 6,  0);
      run("R9", 1, 0, 0, 1, 0, 1, 1, 0, 0, 6,  0);
      run("R9", 1, 0, 1, 0, 0, 1, 0, 0, 0, 6,  0);
      run("R10", 0, 1, 1, 1, 1, 0, 0, 0, 0, 12, 0);
      run("R10", 1, 1, 0, 0, 0, 2, 0, 1, 0, 12, 0);
      // R11: strobe drops before the acknowledge, then exactly at it, then back to back
      run("R11", 1, 0, 0, 0, 0, 4, 1, 0, 0, 2,  0);
      run("R11", 1, 0, 0, 0, 0, 0, 1, 0, 0, 2,  0);
      run("R11", 1, 0, 0, 0, 1, 0, 0, 0, 0, 1,  0);
      run("R12", 1, 0, 0, 0, 0, 3, 1, 0, 0, 9,  1);
      run("R12", 1, 0, 0, 0, 0, 4, 0, 0, 0, 9,  1);
      run("R13", 1, 0, 0, 0, 0, 1, 1, 0, 0, 25, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule